// File: doc/BRIEF.md
# Fast Link Loss Detector

This block watches the stream of classified receive symbols coming out of a PHY receive path and reports a lost link long before the standard link-fail timers would. Each sample comes with a valid strobe and a two-bit class: zero, one or invalid level. Three run-length monitors work side by side. Each one counts consecutive valid samples of its own class and has its own threshold. When an armed monitor reaches its threshold, the link-up output is forced low and a sticky loss flag is set.

Two enable sets exist, one for the 100 Mb mode and one for the 1 Gb mode. A speed-select input chooses the set that is active. Software clears the sticky flag with a read-clear strobe. Link management re-opens the link-up path with a restore pulse. With every monitor disarmed, the block passes the standard link status straight through. A run of a few samples is enough to react, so with symbol-rate sampling the reaction time is on the order of microseconds, not hundreds of milliseconds.

Top module: `link_loss_watch`

## Requirements
- R1: Each monitor keeps a 16-bit run counter that rises by one on every valid sample of its class and stops rising at its threshold. The class codes are 2'b00 zero, 2'b01 one and 2'b10 invalid level. Raising the threshold after the counter has stopped continues the count from the value where it stopped.
- R2: A valid sample of any other class, including the spare code 2'b11, resets a monitor's counter to zero. A cycle with the valid strobe low leaves every counter unchanged, whatever the class input holds.
- R3: A monitor hits when it is armed, its threshold is nonzero and its counter is at or above the threshold. Any hit pulls linkUpOut low in the cycle that follows the clock edge that captured the completing sample.
- R4: speedSel = 0 selects enFast and speedSel = 1 selects enGig. In both sets, bit 0 arms the zero monitor, bit 1 the one monitor and bit 2 the invalid monitor. Changing speedSel takes effect at once on the counts already held.
- R5: lossLatched goes high at the clock edge after any cycle with a hit. It then stays high.
- R6: A readClear pulse clears lossLatched only in a cycle with no hit. In a cycle with a hit, the pulse is ignored.
- R7: After a hit, linkUpOut stays low until a linkRestore pulse arrives in a cycle with no hit. A restore pulse during a hit is ignored.
- R8: While no drop is pending and no monitor hits (for example, with all monitors disarmed), linkUpOut equals linkUpIn.
- R9: A threshold of zero disables its monitor, however long the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, synchronous |
| sampleValid | input | 1 | Sample strobe |
| sampleClass | input | 2 | Sample class: 00 zero, 01 one, 10 invalid, 11 spare |
| speedSel | input | 1 | 0 picks the 100 Mb enable set, 1 picks the 1 Gb set |
| enFast | input | 3 | 100 Mb monitor enables {invalid, one, zero} |
| enGig | input | 3 | 1 Gb monitor enables {invalid, one, zero} |
| thrZero | input | 16 | Run threshold for zero samples |
| thrOne | input | 16 | Run threshold for one samples |
| thrInvalid | input | 16 | Run threshold for invalid samples |
| readClear | input | 1 | Clears the sticky loss flag |
| linkRestore | input | 1 | Re-opens the link-up path after a drop |
| linkUpIn | input | 1 | Link status from standard link handling |
| linkUpOut | output | 1 | Link status after early loss detection |
| lossLatched | output | 1 | Sticky early-loss flag |

## Verification
Three registers matter. A sample changes its counter at the edge that captures it, so a hit, and with it the low linkUpOut, can be seen at the next falling edge. lossLatched and the held drop take one more edge, and a restore or read-clear pulse acts at the edge that captures it. Changes to speedSel, the enables or the thresholds act on linkUpOut combinationally, from counts already held. The bench drives all inputs on falling edges and samples each output at the falling edge where that latency says the result must show. It checks both the cycle before a threshold is reached and the cycle in which it is reached.

// File: rtl/lld_pkg.sv
package lld_pkg;
  localparam int NUM_MON = 3;
  localparam int CNT_W   = 16;

  typedef enum logic [1:0] {
    CLS_ZERO = 2'b00,
    CLS_ONE  = 2'b01,
    CLS_INV  = 2'b10,
    CLS_NONE = 2'b11
  } sym_cls_e;

  // strobes the control hands to the counter datapath
  typedef struct packed {
    logic [NUM_MON-1:0] bump;
    logic [NUM_MON-1:0] clear;
  } run_strobe_t;
endpackage

// File: rtl/lld_datapath.sv
module lld_datapath
  import lld_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  run_strobe_t                   strb,
  input  logic [NUM_MON-1:0][CW-1:0]    thr,
  input  logic [NUM_MON-1:0]            armEn,
  output logic [NUM_MON-1:0][CW-1:0]    runCnt,
  output logic [NUM_MON-1:0]            hit
);
  for (genvar g = 0; g < NUM_MON; g++) begin : g_mon
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
      if (!rstN)
        cnt <= '0;
      else if (strb.clear[g])
        cnt <= '0;
      else if (strb.bump[g] && (cnt < thr[g]))
        cnt <= cnt + 1'b1;
    end

    assign runCnt[g] = cnt;
    assign hit[g]    = armEn[g] && (thr[g] != '0) && (cnt >= thr[g]);
  end
endmodule

// File: rtl/lld_control.sv
module lld_control
  import lld_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleValid,
  input  logic [1:0]         sampleClass,
  input  logic               speedSel,
  input  logic [NUM_MON-1:0] enFast,
  input  logic [NUM_MON-1:0] enGig,
  input  logic               readClear,
  input  logic               linkRestore,
  input  logic [NUM_MON-1:0] hit,
  output run_strobe_t        strb,
  output logic [NUM_MON-1:0] armEn,
  output logic               anyHit,
  output logic               dropHeld,
  output logic               lossLatched
);
  always_comb begin
    for (int i = 0; i < NUM_MON; i++) begin
      strb.bump[i]  = sampleValid && (sampleClass == 2'(i));
      strb.clear[i] = sampleValid && (sampleClass != 2'(i));
    end
  end

  assign armEn  = speedSel ? enGig : enFast;
  assign anyHit = |hit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dropHeld    <= 1'b0;
      lossLatched <= 1'b0;
    end else begin
      if (anyHit)           dropHeld <= 1'b1;
      else if (linkRestore) dropHeld <= 1'b0;

      if (anyHit)           lossLatched <= 1'b1;
      else if (readClear)   lossLatched <= 1'b0;
    end
  end
endmodule

// File: rtl/link_loss_watch.sv
module link_loss_watch
  import lld_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleValid,
  input  logic [1:0]  sampleClass,
  input  logic        speedSel,
  input  logic [2:0]  enFast,
  input  logic [2:0]  enGig,
  input  logic [15:0] thrZero,
  input  logic [15:0] thrOne,
  input  logic [15:0] thrInvalid,
  input  logic        readClear,
  input  logic        linkRestore,
  input  logic        linkUpIn,
  output logic        linkUpOut,
  output logic        lossLatched
);
  run_strobe_t                     strb;
  logic [NUM_MON-1:0]              armEn;
  logic [NUM_MON-1:0]              hit;
  logic [NUM_MON-1:0][CNT_W-1:0]   thr;
  logic [NUM_MON-1:0][CNT_W-1:0]   runCnt;
  logic                            anyHit;
  logic                            dropHeld;

  assign thr[CLS_ZERO] = thrZero;
  assign thr[CLS_ONE]  = thrOne;
  assign thr[CLS_INV]  = thrInvalid;

  lld_control u_ctl (
    .clk(clk), .rstN(rstN),
    .sampleValid(sampleValid), .sampleClass(sampleClass),
    .speedSel(speedSel), .enFast(enFast), .enGig(enGig),
    .readClear(readClear), .linkRestore(linkRestore),
    .hit(hit), .strb(strb), .armEn(armEn), .anyHit(anyHit),
    .dropHeld(dropHeld), .lossLatched(lossLatched)
  );

  lld_datapath #(.CW(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .thr(thr),
    .armEn(armEn), .runCnt(runCnt), .hit(hit)
  );

  assign linkUpOut = linkUpIn && !dropHeld && !anyHit;
endmodule

// File: rtl/link_loss_watch_chk.sv
module link_loss_watch_chk (
  input logic        clk,
  input logic        rstN,
  input logic        sampleValid,
  input logic [1:0]  sampleClass,
  input logic        readClear,
  input logic        linkRestore,
  input logic        linkUpOut,
  input logic        lossLatched,
  input logic        anyHit,
  input logic        dropHeld,
  input logic [2:0][15:0] runCnt,
  input logic [2:0][15:0] thr
);
  assert_saturate_R1: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && sampleClass == 2'b00 && runCnt[0] >= thr[0]) |=> (runCnt[0] == $past(runCnt[0])));

  assert_run_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && sampleClass != 2'b00) |=> (runCnt[0] == '0));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(runCnt));

  assert_drop_on_hit_R3: assert property (@(posedge clk) disable iff (!rstN)
    anyHit |-> !linkUpOut);

  assert_latch_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    anyHit |=> lossLatched);

  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (lossLatched && !readClear) |=> lossLatched);

  assert_clear_blocked_R6: assert property (@(posedge clk) disable iff (!rstN)
    (readClear && anyHit) |=> lossLatched);

  assert_drop_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (dropHeld && !linkRestore) |=> (dropHeld && !linkUpOut));

  assert_restore_only_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dropHeld) |-> ($past(linkRestore) && !$past(anyHit)));
endmodule

bind link_loss_watch link_loss_watch_chk u_chk (
  .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleClass(sampleClass),
  .readClear(readClear), .linkRestore(linkRestore), .linkUpOut(linkUpOut),
  .lossLatched(lossLatched), .anyHit(anyHit), .dropHeld(dropHeld),
  .runCnt(runCnt), .thr(thr)
);

// File: tb/link_loss_watch_bench.sv
module link_loss_watch_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] C_ZERO = 2'b00, C_ONE = 2'b01, C_INV = 2'b10, C_NONE = 2'b11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic [1:0] sampleClass = 2'b00;
  logic speedSel = 1'b0;
  logic [2:0] enFast = 3'b111, enGig = 3'b111;
  logic [15:0] thrZero = 16'd100, thrOne = 16'd100, thrInvalid = 16'd100;
  logic readClear = 1'b0, linkRestore = 1'b0, linkUpIn = 1'b1;
  logic linkUpOut, lossLatched;
  int nChecks = 0, nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_loss_watch u_link_loss_watch (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleClass(sampleClass),
    .speedSel(speedSel), .enFast(enFast), .enGig(enGig),
    .thrZero(thrZero), .thrOne(thrOne), .thrInvalid(thrInvalid),
    .readClear(readClear), .linkRestore(linkRestore), .linkUpIn(linkUpIn),
    .linkUpOut(linkUpOut), .lossLatched(lossLatched)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic send(input logic [1:0] cls, input int n);
    for (int i = 0; i < n; i++) begin
      sampleValid = 1'b1;
      sampleClass = cls;
      step();
    end
    sampleValid = 1'b0;
  endtask

  task automatic recover();
    send(C_NONE, 1);
    linkRestore = 1'b1;
    readClear   = 1'b1;
    step();
    linkRestore = 1'b0;
    readClear   = 1'b0;
  endtask

  task automatic t_reset();
    chk("R8 reset linkUpOut", linkUpOut, 1'b1);
    chk("R5 reset lossLatched", lossLatched, 1'b0);
  endtask

  task automatic t_zero_run();
    thrZero = 16'd4;
    send(C_ZERO, 3);
    chk("R1 below threshold", linkUpOut, 1'b1);
    send(C_ZERO, 1);
    chk("R3 drop at threshold", linkUpOut, 1'b0);
    chk("R5 latch not yet", lossLatched, 1'b0);
    send(C_ONE, 1);
    chk("R5 latch set", lossLatched, 1'b1);
    chk("R7 drop held", linkUpOut, 1'b0);
    linkRestore = 1'b1; step(); linkRestore = 1'b0;
    chk("R7 restored", linkUpOut, 1'b1);
    chk("R5 sticky after restore", lossLatched, 1'b1);
    readClear = 1'b1; step(); readClear = 1'b0;
    chk("R6 read clear", lossLatched, 1'b0);
    thrZero = 16'd100;
    recover();
  endtask

  task automatic t_blocked_clear();
    thrInvalid = 16'd2;
    send(C_INV, 2);
    chk("R3 invalid drop", linkUpOut, 1'b0);
    readClear = 1'b1; linkRestore = 1'b1; step();
    readClear = 1'b0; linkRestore = 1'b0;
    chk("R6 clear blocked during hit", lossLatched, 1'b1);
    chk("R7 restore ignored during hit", linkUpOut, 1'b0);
    recover();
    chk("R7 restore after hit", linkUpOut, 1'b1);
    chk("R6 clear after hit", lossLatched, 1'b0);
    thrInvalid = 16'd100;
  endtask

  task automatic t_interrupt();
    thrOne = 16'd3;
    send(C_ONE, 2); send(C_ZERO, 1); send(C_ONE, 2);
    chk("R2 run broken by other class", linkUpOut, 1'b1);
    sampleValid = 1'b0; sampleClass = C_ZERO; step();
    send(C_ONE, 1);
    chk("R2 gap keeps count", linkUpOut, 1'b0);
    recover();
    chk("R2 recovered", linkUpOut, 1'b1);
    thrOne = 16'd100;
  endtask

  task automatic t_speed();
    thrOne = 16'd3; enFast = 3'b001; enGig = 3'b010; speedSel = 1'b0;
    send(C_ONE, 3);
    chk("R4 fast set ignores ones", linkUpOut, 1'b1);
    speedSel = 1'b1; step();
    chk("R4 gig set arms ones", linkUpOut, 1'b0);
    recover();
    speedSel = 1'b0; enFast = 3'b111; enGig = 3'b111; thrOne = 16'd100;
  endtask

  task automatic t_saturate();
    enFast = 3'b110; thrZero = 16'd2;
    send(C_ZERO, 5);
    chk("R3 disarmed no drop", linkUpOut, 1'b1);
    thrZero = 16'd4; enFast = 3'b111; step();
    chk("R1 count saturated at old threshold", linkUpOut, 1'b1);
    send(C_ZERO, 1);
    chk("R1 count three", linkUpOut, 1'b1);
    send(C_ZERO, 1);
    chk("R1 count reaches new threshold", linkUpOut, 1'b0);
    recover();
    thrZero = 16'd100;
  endtask

  task automatic t_thr_zero();
    thrZero = 16'd0;
    send(C_ZERO, 5);
    chk("R9 zero threshold no drop", linkUpOut, 1'b1);
    chk("R9 zero threshold no latch", lossLatched, 1'b0);
    thrZero = 16'd100;
    send(C_NONE, 1);
  endtask

  task automatic t_transparent();
    enFast = 3'b000; enGig = 3'b000; thrZero = 16'd2;
    send(C_ZERO, 5);
    linkUpIn = 1'b0; step();
    chk("R8 follows low", linkUpOut, 1'b0);
    linkUpIn = 1'b1; step();
    chk("R8 follows high", linkUpOut, 1'b1);
    chk("R8 no latch when disarmed", lossLatched, 1'b0);
    enFast = 3'b111; enGig = 3'b111; thrZero = 16'd100;
    send(C_NONE, 1);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) step();
    rstN = 1'b1;
    step();
    t_reset();
    t_zero_run();
    t_blocked_clear();
    t_interrupt();
    t_speed();
    t_saturate();
    t_thr_zero();
    t_transparent();
    finish_run();
  end
endmodule